// File: doc/BRIEF.md
# Folded Single-Port Word Memory

This block is a single-port, word-addressed memory whose storage is arranged as a folded array. There are fewer physical rows than logical words, and each row is wide enough to hold several words side by side. An `ADDR_W`-bit address splits into two fields. The upper field picks one physical row through a predecoded one-hot row decoder. The lower `FOLD_LOG2` bits pick one word within that row through a separate column multiplexer for each data bit. With the default parameters the block holds 2048 words of 16 bits as 256 rows of 128 bits, and each of the 16 read bits comes from its own 8:1 multiplexer.

Each clock edge performs exactly one access, chosen by `wr_en`. A write merges the new word into the addressed slice of the selected row and leaves the other words of that row alone. A read captures the addressed word into the output register.

A small access-state register records which operation the last edge carried out. It has three states:
- `ACC_IDLE` is entered on reset.
- `ACC_READ` is entered when `wr_en` is low at an edge.
- `ACC_WRITE` is entered when `wr_en` is high at an edge.

Every state can go to `ACC_READ` or to `ACC_WRITE` on the next edge. Only reset returns the register to `ACC_IDLE`. The output register loads only on a transition into `ACC_READ`.

Top module: `folded_sram`

## Requirements
- R1: A word written to any address reads back unchanged, and all 2^ADDR_W addresses hold independent words.
- R2: Address bits [ADDR_W-1:FOLD_LOG2] select the physical row and bits [FOLD_LOG2-1:0] select the word within it. Word j of a row occupies row bits j*WORD_W through j*WORD_W+WORD_W-1, so addresses that differ only in the row field or only in the column field never alias.
- R3: A write changes only the addressed WORD_W-bit slice of the selected row. The other words of that row and all other rows keep their contents.
- R4: Read data is registered. When `wr_en` is low at a rising edge, `rd_data` shows the word at `addr` from that edge onward.
- R5: When `wr_en` is high at a rising edge, `rd_data` keeps its previous value.
- R6: While `rst_n` is low, `rd_data` is 0 and the access state is `ACC_IDLE`. Reset does not clear the stored words.
- R7: Exactly one row-select line is active at every edge, and it is the line numbered by the row field.
- R8: Each predecoder group, which decodes one pair of row address bits, drives exactly one of its four lines.
- R9: A later write to an address replaces the earlier word there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the access state and read register |
| addr | input | ADDR_W | Word address: row field high, column field low |
| wr_en | input | 1 | 1 = write this edge, 0 = read this edge |
| wr_data | input | 2^WORD_LOG2 | Word to be written |
| rd_data | output | 2^WORD_LOG2 | Registered read word |

## Verification
Suppose the column multiplexer order differs from the write slice mapping. A word then comes back from a neighbouring slot of the same row, and this shows on the first read of a row whose slots hold distinct words. A wrong row decode shows up as aliasing between addresses that differ only in their high bits, once one of them is read back one edge after its address. Errors in the write mask corrupt other words of the same row, and they stay hidden until those neighbours are read. For that reason the stimulus fills several slots of one row before reading any of them back.

// File: rtl/fold_mem_pkg.sv
package fold_mem_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } access_e;

    function automatic int unsigned pair_groups(int unsigned bits);
        return (bits + 1) / 2;
    endfunction

endpackage

// File: rtl/row_predecoder.sv
module row_predecoder #(
    parameter int unsigned ROW_BITS = 8,
    localparam int unsigned ROWS    = 1 << ROW_BITS,
    localparam int unsigned GROUPS  = fold_mem_pkg::pair_groups(ROW_BITS),
    localparam int unsigned PAD_W   = GROUPS * 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ROW_BITS-1:0] row_addr,
    output logic [ROWS-1:0]     word_line
);

    logic [PAD_W-1:0]          addr_pad;
    logic [GROUPS-1:0][3:0]    group_hot;

    assign addr_pad = PAD_W'(row_addr);

    // Each pair of address bits becomes a 1-of-4 group.
    for (genvar g = 0; g < GROUPS; g++) begin : g_pair
        assign group_hot[g] = 4'b0001 << addr_pad[2*g +: 2];

        assert_group_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot(group_hot[g]));
    end

    // Each word line ANDs one line from every group.
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            logic             hit;
            logic [PAD_W-1:0] ridx;
            ridx = PAD_W'(r);
            hit  = 1'b1;
            for (int g = 0; g < GROUPS; g++) begin
                hit = hit & group_hot[g][ridx[2*g +: 2]];
            end
            word_line[r] = hit;
        end
    end

    assert_row_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(word_line));
    assert_row_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_line[row_addr]);

endmodule

// File: rtl/fold_row_array.sv
module fold_row_array #(
    parameter int unsigned ROW_BITS  = 8,
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned COL_BITS  = 3,
    localparam int unsigned ROWS     = 1 << ROW_BITS,
    localparam int unsigned COLS     = 1 << COL_BITS,
    localparam int unsigned ROW_W    = WORD_W * COLS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ROWS-1:0]     word_line,
    input  logic [COL_BITS-1:0] col_sel,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_word,
    output logic [ROW_W-1:0]    row_data
);

    logic [ROW_W-1:0] cells [ROWS];
    logic [ROW_W-1:0] slice_mask;
    logic [ROW_W-1:0] wr_wide;

    // Word j lives at bits j*WORD_W .. j*WORD_W+WORD_W-1.
    assign slice_mask = ROW_W'({WORD_W{1'b1}}) << (int'(col_sel) * WORD_W);
    assign wr_wide    = {COLS{wr_word}};

    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            if (wr_en && word_line[r]) begin
                cells[r] <= (cells[r] & ~slice_mask) | (wr_wide & slice_mask);
            end
        end
    end

    // The selected row is gated onto the shared column lines.
    always_comb begin
        row_data = '0;
        for (int r = 0; r < ROWS; r++) begin
            row_data = row_data | (cells[r] & {ROW_W{word_line[r]}});
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row_chk
        assert_idle_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && word_line[r]) |=> $stable(cells[r]));
        assert_keep_neighbours_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && word_line[r]) |=>
            ((cells[r] & ~$past(slice_mask)) == ($past(cells[r]) & ~$past(slice_mask))));
    end

endmodule

// File: rtl/fold_col_mux.sv
module fold_col_mux #(
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned COL_BITS = 3,
    localparam int unsigned COLS    = 1 << COL_BITS,
    localparam int unsigned ROW_W   = WORD_W * COLS
) (
    input  logic [ROW_W-1:0]    row_data,
    input  logic [COL_BITS-1:0] col_sel,
    output logic [WORD_W-1:0]   word
);

    // One COLS:1 multiplexer per output bit, tap j matching write slice j.
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        logic [COLS-1:0] taps;
        for (genvar j = 0; j < COLS; j++) begin : g_tap
            assign taps[j] = row_data[j*WORD_W + b];
        end
        assign word[b] = taps[col_sel];
    end

endmodule

// File: rtl/folded_sram.sv
module folded_sram #(
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned WORD_LOG2 = 4,
    parameter int unsigned FOLD_LOG2 = 3,
    localparam int unsigned WORD_W   = 1 << WORD_LOG2,
    localparam int unsigned ROW_BITS = ADDR_W - FOLD_LOG2,
    localparam int unsigned ROWS     = 1 << ROW_BITS,
    localparam int unsigned ROW_W    = WORD_W << FOLD_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data
);

    import fold_mem_pkg::*;

    access_e                acc_q;
    access_e                acc_d;
    logic [ROW_BITS-1:0]    row_field;
    logic [FOLD_LOG2-1:0]   col_field;
    logic [ROWS-1:0]        word_line;
    logic [ROW_W-1:0]       row_data;
    logic [WORD_W-1:0]      fetched;

    assign row_field = addr[ADDR_W-1:FOLD_LOG2];
    assign col_field = addr[FOLD_LOG2-1:0];

    row_predecoder #(
        .ROW_BITS (ROW_BITS)
    ) u_rowdec (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_addr  (row_field),
        .word_line (word_line)
    );

    fold_row_array #(
        .ROW_BITS (ROW_BITS),
        .WORD_W   (WORD_W),
        .COL_BITS (FOLD_LOG2)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_line (word_line),
        .col_sel   (col_field),
        .wr_en     (wr_en),
        .wr_word   (wr_data),
        .row_data  (row_data)
    );

    fold_col_mux #(
        .WORD_W   (WORD_W),
        .COL_BITS (FOLD_LOG2)
    ) u_colmux (
        .row_data (row_data),
        .col_sel  (col_field),
        .word     (fetched)
    );

    // Next access kind.
    always_comb begin
        unique case (wr_en)
            1'b1:    acc_d = ACC_WRITE;
            default: acc_d = ACC_READ;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= ACC_IDLE;
        else        acc_q <= acc_d;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            unique case (acc_d)
                ACC_READ: rd_data <= fetched;
                default:  rd_data <= rd_data;
            endcase
        end
    end

    assert_hold_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q == ACC_WRITE) |-> $stable(rd_data));
    assert_state_follows_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (acc_q == ($past(wr_en) ? ACC_WRITE : ACC_READ)));

endmodule

// File: tb/folded_sram_bench.sv
module folded_sram_bench;

    localparam int ADDR_W = 11;
    localparam int WORD_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic [WORD_W-1:0] wr_data = '0;
    logic [WORD_W-1:0] rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    folded_sram u_folded_sram (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    // {req[3:0], we, addr[10:0], data[15:0], expected rd_data after the edge}
    // Address 0x028 is row 5 col 0; 0x02F row 5 col 7; 0x0A8 row 21 col 0.
    localparam int NVEC = 16;
    localparam logic [47:0] VEC [NVEC] = '{
        {4'd5, 1'b1, 11'h028, 16'h1111, 16'h0000},  // R5 hold after reset value
        {4'd5, 1'b1, 11'h02F, 16'h7777, 16'h0000},  // R5
        {4'd5, 1'b1, 11'h02B, 16'h3333, 16'h0000},  // R5
        {4'd2, 1'b0, 11'h028, 16'h0000, 16'h1111},  // R2 col 0
        {4'd2, 1'b0, 11'h02F, 16'h0000, 16'h7777},  // R2 col 7
        {4'd4, 1'b0, 11'h02B, 16'h0000, 16'h3333},  // R4 col 3
        {4'd5, 1'b1, 11'h02B, 16'hABCD, 16'h3333},  // R5 write holds
        {4'd9, 1'b0, 11'h02B, 16'h0000, 16'hABCD},  // R9 overwrite
        {4'd3, 1'b0, 11'h028, 16'h0000, 16'h1111},  // R3 neighbour kept
        {4'd5, 1'b1, 11'h7FF, 16'hFFFF, 16'h1111},  // R5
        {4'd5, 1'b1, 11'h000, 16'h8001, 16'h1111},  // R5
        {4'd1, 1'b0, 11'h7FF, 16'h0000, 16'hFFFF},  // R1 top address
        {4'd1, 1'b0, 11'h000, 16'h0000, 16'h8001},  // R1 bottom address
        {4'd5, 1'b1, 11'h0A8, 16'h5A5A, 16'h8001},  // R5
        {4'd2, 1'b0, 11'h028, 16'h0000, 16'h1111},  // R2 row-only difference
        {4'd2, 1'b0, 11'h0A8, 16'h0000, 16'h5A5A}   // R2
    };

    function automatic logic [WORD_W-1:0] pattern(int a);
        return WORD_W'(a * 40503) ^ 16'h5A5A;
    endfunction

    task automatic check(string req, logic [WORD_W-1:0] got, logic [WORD_W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: rd_data=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic step(logic we, logic [ADDR_W-1:0] a, logic [WORD_W-1:0] d);
        wr_en   = we;
        addr    = a;
        wr_data = d;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R6 reset value
        repeat (3) @(negedge clk);
        check("R6", rd_data, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [47:0] v;
            v = VEC[i];
            step(v[43], v[42:32], v[31:16]);
            check($sformatf("R%0d vec%0d", v[47:44], i), rd_data, v[15:0]);
        end

        // R1 full sweep: write every address then read each back.
        for (int a = 0; a < (1 << ADDR_W); a++) begin
            step(1'b1, ADDR_W'(a), pattern(a));
        end
        for (int a = 0; a < (1 << ADDR_W); a++) begin
            step(1'b0, ADDR_W'(a), '0);
            if (a % 64 == 0 || a == (1 << ADDR_W) - 1)
                check($sformatf("R1 addr %0d", a), rd_data, pattern(a));
            else if (rd_data !== pattern(a))
                check($sformatf("R1 addr %0d", a), rd_data, pattern(a));
        end

        // R6 reset clears output but keeps storage.
        wr_en = 1'b0;
        addr  = 11'h123;
        rst_n = 1'b0;
        @(negedge clk);
        check("R6 reset output", rd_data, '0);
        rst_n = 1'b1;
        step(1'b0, 11'h123, '0);
        check("R6 storage kept", rd_data, pattern(11'h123));

        // R3 write one slot of a full row, read its neighbours.
        step(1'b1, 11'h124, 16'h0F0F);
        step(1'b0, 11'h123, '0);
        check("R3 left neighbour", rd_data, pattern(11'h123));
        step(1'b0, 11'h125, '0);
        check("R3 right neighbour", rd_data, pattern(11'h125));
        step(1'b0, 11'h124, '0);
        check("R9 new word", rd_data, 16'h0F0F);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule